// File: doc/BRIEF.md
# Sprite Attribute Cache with Write Snooping

This block holds a small local copy of the leading part of the sprite attribute table. The table itself lives in video memory. The block watches every write into video memory. When a write falls inside the window that the current mode settings assign to the table, the block updates its copy in the same clock edge. The sprite scanner can then read sprite positions and sizes from the copy through a private read port, without taking video-memory bandwidth.

Each sprite entry in the table is eight bytes long. Only its first four bytes are kept, packed densely, so the copy is 320 bytes: four bytes for each of 80 sprites. The start of the window comes from an 8-bit base setting, adjusted by the memory-size and line-width modes. Word writes fill a pair of neighbouring cache bytes. Byte writes fill one.

Top module: `sat_snoop_cache`

## Requirements
- R1: The window base is `sat_base` multiplied by 512, as a 17-bit address.
- R2: While `big_mem_en` is 0, bit 16 of the base is forced to 0. For example, `sat_base`=0x90 gives base 0x02000, and gives 0x12000 only while `big_mem_en` is 1.
- R3: While `wide_line_en` is 1, the low 10 bits of the base are forced to 0. For example, `sat_base`=0x11 gives base 0x02000 instead of 0x02200.
- R4: A write changes no cache byte while `mode5_en` is 0, or when bit 2 of `wr_addr` is 1.
- R5: Only addresses from the base up to, but not including, base + 640 can change the cache. A write outside that range leaves every cache byte unchanged.
- R6: With offset = `wr_addr` − base, the cache index is built from two parts. Offset bits 1:0 become index bits 1:0, and offset bits 9:3 become index bits 8:2. In other words, index = (offset & 3) | ((offset >> 1) & 0x1FC).
- R7: A word write (`wr_word`=1) stores `wr_data[15:8]` at the index and `wr_data[7:0]` at the index XOR 1.
- R8: A byte write (`wr_word`=0) stores only `wr_data[7:0]`, at the index. It leaves the paired byte untouched.
- R9: Reset clears all 320 cache bytes to zero.
- R10: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is presented. An `rd_addr` of 320 or more reads as zero.
- R11: A read of a location that is written on the same clock edge returns the old value. The new value appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Strobe for a video-memory write |
| wr_word | input | 1 | 1 for a word write, 0 for a byte write |
| wr_addr | input | 17 | Video-memory byte address of the write |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| mode5_en | input | 1 | Enables snooping |
| big_mem_en | input | 1 | Enables 128 KB addressing of the base |
| wide_line_en | input | 1 | Wide-line mode; aligns the base to 1 KB |
| sat_base | input | 8 | Sprite-table base setting |
| rd_addr | input | 9 | Cache byte index for the scanner read |
| rd_data | output | 8 | Registered read data |

## Verification
The bound checker checks several properties on every cycle:
- the masking of the base address by the memory-size and line-width modes;
- the suppression of cache stores when mode 5 is off, when address bit 2 is set, or when no write is strobed;
- that a byte write uses a single store port;
- that the two bytes of a word write land on paired indices;
- that every store index stays inside the cache;
- that out-of-range reads return zero.

Other behaviour shows only in the bench's scenarios. These cover the exact index packing, byte placement within a word, the boundaries of the address window, read-during-write ordering, and clearing by reset. For these, the bench compares the read port against a behavioural model on every clock and runs directed read-backs of hand-computed bytes.

// File: rtl/sat_snoop_pkg.sv
package sat_snoop_pkg;

  // Default geometry of the snooped sprite table copy
  localparam int SNOOP_ADDR_W     = 17;   // video-memory byte address width
  localparam int SNOOP_DATA_W     = 16;   // write data width (one word)
  localparam int SNOOP_BASE_W     = 8;    // base setting width
  localparam int SNOOP_BASE_SHIFT = 9;    // base setting granularity, 512 bytes
  localparam int SNOOP_NARROW_W   = 16;   // address width without big memory
  localparam int SNOOP_WIDE_ALIGN = 10;   // base alignment in wide-line mode
  localparam int SNOOP_CACHE_BYTES = 320; // 80 sprites x 4 cached bytes

  // Width of an index that covers a cache of the given size
  function automatic int idx_width(input int bytes);
    return (bytes > 1) ? $clog2(bytes) : 1;
  endfunction

endpackage

// File: rtl/sat_snoop_base.sv
module sat_snoop_base #(
  parameter int ADDR_W     = sat_snoop_pkg::SNOOP_ADDR_W,
  parameter int BASE_W     = sat_snoop_pkg::SNOOP_BASE_W,
  parameter int BASE_SHIFT = sat_snoop_pkg::SNOOP_BASE_SHIFT,
  parameter int NARROW_W   = sat_snoop_pkg::SNOOP_NARROW_W,
  parameter int WIDE_ALIGN = sat_snoop_pkg::SNOOP_WIDE_ALIGN
) (
  input  logic [BASE_W-1:0] sat_base,
  input  logic              big_mem_en,
  input  logic              wide_line_en,
  output logic [ADDR_W-1:0] base_addr
);

  localparam logic [ADDR_W-1:0] ALL_ONES    = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NARROW_MASK = ALL_ONES >> (ADDR_W - NARROW_W);
  localparam logic [ADDR_W-1:0] WIDE_MASK   = ALL_ONES << WIDE_ALIGN;

  logic [ADDR_W-1:0] raw_base;
  logic [ADDR_W-1:0] sized_base;

  // Scale the base setting to a byte address
  always_comb begin
    raw_base = ADDR_W'(sat_base) << BASE_SHIFT;
  end

  // Fold away the top address bit when big memory is off
  always_comb begin
    if (big_mem_en) begin
      sized_base = raw_base;
    end else begin
      sized_base = raw_base & NARROW_MASK;
    end
  end

  // Force 1 KB alignment when wide lines are selected
  always_comb begin
    if (wide_line_en) begin
      base_addr = sized_base & WIDE_MASK;
    end else begin
      base_addr = sized_base;
    end
  end

endmodule

// File: rtl/sat_snoop_decode.sv
module sat_snoop_decode #(
  parameter int ADDR_W      = sat_snoop_pkg::SNOOP_ADDR_W,
  parameter int DATA_W      = sat_snoop_pkg::SNOOP_DATA_W,
  parameter int CACHE_BYTES = sat_snoop_pkg::SNOOP_CACHE_BYTES,
  parameter int IDX_W       = sat_snoop_pkg::idx_width(CACHE_BYTES),
  localparam int BYTE_W     = DATA_W / 2
) (
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode5_en,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              we_a,
  output logic [IDX_W-1:0]  idx_a,
  output logic [BYTE_W-1:0] dat_a,
  output logic              we_b,
  output logic [IDX_W-1:0]  idx_b,
  output logic [BYTE_W-1:0] dat_b
);

  // Window covers twice the cache size, since half of each entry is skipped
  localparam int CMP_W = ADDR_W + 1;
  localparam logic [CMP_W-1:0] SPAN = CMP_W'(2 * CACHE_BYTES);
  localparam logic [IDX_W-1:0] HI_MASK = ~IDX_W'(3);

  logic [CMP_W-1:0] addr_x;
  logic [CMP_W-1:0] lo_x;
  logic [CMP_W-1:0] hi_x;
  logic             in_window;
  logic             half_ok;
  logic             hit;
  logic [IDX_W:0]   offset;
  logic [IDX_W-1:0] packed_idx;

  // Window compare, one bit wider so base + span cannot wrap
  always_comb begin
    addr_x    = {1'b0, wr_addr};
    lo_x      = {1'b0, base_addr};
    hi_x      = lo_x + SPAN;
    in_window = (addr_x >= lo_x) && (addr_x < hi_x);
  end

  // Only the leading half of every 8-byte entry is kept
  always_comb begin
    half_ok = ~wr_addr[2];
    hit     = wr_en & mode5_en & half_ok & in_window;
  end

  // Pack the offset: drop bit 2, shift the entry number down by one
  always_comb begin
    offset     = wr_addr[IDX_W:0] - base_addr[IDX_W:0];
    packed_idx = IDX_W'(offset[1:0]) | (IDX_W'(offset >> 1) & HI_MASK);
  end

  // Port A takes the byte at the index, port B the paired byte
  always_comb begin
    we_a  = hit;
    idx_a = packed_idx;
    dat_a = wr_word ? wr_data[DATA_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
    we_b  = hit & wr_word;
    idx_b = packed_idx ^ IDX_W'(1);
    dat_b = wr_data[BYTE_W-1:0];
  end

endmodule

// File: rtl/sat_snoop_store.sv
module sat_snoop_store #(
  parameter int CACHE_BYTES = sat_snoop_pkg::SNOOP_CACHE_BYTES,
  parameter int IDX_W       = sat_snoop_pkg::idx_width(CACHE_BYTES),
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [BYTE_W-1:0] dat_a,
  input  logic              we_b,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [BYTE_W-1:0] dat_b,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] mem_q [CACHE_BYTES];
  logic [BYTE_W-1:0] rd_nxt;
  logic [BYTE_W-1:0] rd_q;

  // One register per cache byte with its own enable and next value
  for (genvar g = 0; g < CACHE_BYTES; g++) begin : g_cell
    logic              sel_a;
    logic              sel_b;
    logic              cell_en;
    logic [BYTE_W-1:0] cell_nxt;

    always_comb begin
      sel_a   = we_a && (idx_a == IDX_W'(g));
      sel_b   = we_b && (idx_b == IDX_W'(g));
      cell_en = sel_a | sel_b;
      if (sel_a) begin
        cell_nxt = dat_a;
      end else if (sel_b) begin
        cell_nxt = dat_b;
      end else begin
        cell_nxt = mem_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (cell_en) begin
        mem_q[g] <= cell_nxt;
      end
    end
  end

  // Read sees the contents before this edge's writes
  always_comb begin
    if (rd_addr < IDX_W'(CACHE_BYTES)) begin
      rd_nxt = mem_q[rd_addr];
    end else begin
      rd_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/sat_snoop_cache.sv
module sat_snoop_cache #(
  parameter int ADDR_W      = sat_snoop_pkg::SNOOP_ADDR_W,
  parameter int DATA_W      = sat_snoop_pkg::SNOOP_DATA_W,
  parameter int BASE_W      = sat_snoop_pkg::SNOOP_BASE_W,
  parameter int BASE_SHIFT  = sat_snoop_pkg::SNOOP_BASE_SHIFT,
  parameter int NARROW_W    = sat_snoop_pkg::SNOOP_NARROW_W,
  parameter int WIDE_ALIGN  = sat_snoop_pkg::SNOOP_WIDE_ALIGN,
  parameter int CACHE_BYTES = sat_snoop_pkg::SNOOP_CACHE_BYTES,
  localparam int IDX_W      = sat_snoop_pkg::idx_width(CACHE_BYTES),
  localparam int BYTE_W     = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode5_en,
  input  logic              big_mem_en,
  input  logic              wide_line_en,
  input  logic [BASE_W-1:0] sat_base,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  logic [ADDR_W-1:0] base_addr;
  logic              we_a;
  logic [IDX_W-1:0]  idx_a;
  logic [BYTE_W-1:0] dat_a;
  logic              we_b;
  logic [IDX_W-1:0]  idx_b;
  logic [BYTE_W-1:0] dat_b;

  sat_snoop_base #(
    .ADDR_W     (ADDR_W),
    .BASE_W     (BASE_W),
    .BASE_SHIFT (BASE_SHIFT),
    .NARROW_W   (NARROW_W),
    .WIDE_ALIGN (WIDE_ALIGN)
  ) u_base (
    .sat_base     (sat_base),
    .big_mem_en   (big_mem_en),
    .wide_line_en (wide_line_en),
    .base_addr    (base_addr)
  );

  sat_snoop_decode #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CACHE_BYTES (CACHE_BYTES),
    .IDX_W       (IDX_W)
  ) u_decode (
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode5_en  (mode5_en),
    .base_addr (base_addr),
    .we_a      (we_a),
    .idx_a     (idx_a),
    .dat_a     (dat_a),
    .we_b      (we_b),
    .idx_b     (idx_b),
    .dat_b     (dat_b)
  );

  sat_snoop_store #(
    .CACHE_BYTES (CACHE_BYTES),
    .IDX_W       (IDX_W),
    .BYTE_W      (BYTE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_a    (we_a),
    .idx_a   (idx_a),
    .dat_a   (dat_a),
    .we_b    (we_b),
    .idx_b   (idx_b),
    .dat_b   (dat_b),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/sat_snoop_checker.sv
module sat_snoop_checker #(
  parameter int ADDR_W      = 17,
  parameter int NARROW_W    = 16,
  parameter int WIDE_ALIGN  = 10,
  parameter int CACHE_BYTES = 320,
  parameter int IDX_W       = 9,
  parameter int BYTE_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_word,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              mode5_en,
  input logic              big_mem_en,
  input logic              wide_line_en,
  input logic [IDX_W-1:0]  rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [ADDR_W-1:0] base_addr,
  input logic              we_a,
  input logic [IDX_W-1:0]  idx_a,
  input logic              we_b,
  input logic [IDX_W-1:0]  idx_b
);

  localparam logic [ADDR_W-1:0] LOW_ALIGN = ~({ADDR_W{1'b1}} << WIDE_ALIGN);

  a_r2_narrow_base: assert property (@(posedge clk) disable iff (!rst_n)
    !big_mem_en |-> ((base_addr >> NARROW_W) == '0));

  a_r3_wide_align: assert property (@(posedge clk) disable iff (!rst_n)
    wide_line_en |-> ((base_addr & LOW_ALIGN) == '0));

  a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mode5_en |-> !(we_a || we_b));

  a_r4_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr[2] |-> !(we_a || we_b));

  a_r5_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(we_a || we_b));

  a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    we_a |-> (idx_a < IDX_W'(CACHE_BYTES)));

  a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
    we_b |-> (we_a && (idx_b == (idx_a ^ IDX_W'(1)))));

  a_r8_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word) |-> !we_b);

  a_r10_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= IDX_W'(CACHE_BYTES)) |=> (rd_data == '0));

endmodule

bind sat_snoop_cache sat_snoop_checker #(
  .ADDR_W      (ADDR_W),
  .NARROW_W    (NARROW_W),
  .WIDE_ALIGN  (WIDE_ALIGN),
  .CACHE_BYTES (CACHE_BYTES),
  .IDX_W       (IDX_W),
  .BYTE_W      (BYTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_word      (wr_word),
  .wr_addr      (wr_addr),
  .mode5_en     (mode5_en),
  .big_mem_en   (big_mem_en),
  .wide_line_en (wide_line_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .base_addr    (base_addr),
  .we_a         (we_a),
  .idx_a        (idx_a),
  .we_b         (we_b),
  .idx_b        (idx_b)
);

// File: tb/tb_sat_snoop_cache.sv
module tb_sat_snoop_cache;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 320;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_word;
  logic [16:0] wr_addr;
  logic [15:0] wr_data;
  logic        mode5_en;
  logic        big_mem_en;
  logic        wide_line_en;
  logic [7:0]  sat_base;
  logic [8:0]  rd_addr;
  logic [7:0]  rd_data;

  sat_snoop_cache dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_word      (wr_word),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .mode5_en     (mode5_en),
    .big_mem_en   (big_mem_en),
    .wide_line_en (wide_line_en),
    .sat_base     (sat_base),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int        n_chk = 0;
  int        n_fail = 0;
  bit        live = 0;
  logic [7:0] model [NB];
  logic [7:0] exp_rd = 8'h00;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Behavioural model: window base, packing and byte placement from R1..R8
  task automatic model_write();
    int b;
    int a;
    int off;
    int ix;
    b = int'(sat_base) * 512;
    if (!big_mem_en) b = b % 65536;
    if (wide_line_en) b = (b / 1024) * 1024;
    a = int'(wr_addr);
    if (!mode5_en || wr_addr[2] || a < b || a >= b + 2 * NB) return;
    off = a - b;
    ix = (off & 3) | ((off >> 1) & 'h1FC);
    if (wr_word) begin
      model[ix] = wr_data[15:8];
      model[ix ^ 1] = wr_data[7:0];
    end else begin
      model[ix] = wr_data[7:0];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) model[i] = 8'h00;
      exp_rd = 8'h00;
    end else begin
      exp_rd = (int'(rd_addr) < NB) ? model[rd_addr] : 8'h00;
      if (wr_en) model_write();
    end
  end

  // Cycle-by-cycle comparison of the read port (R10, R11)
  always @(negedge clk) begin
    if (live && rst_n) check("R11 per-cycle read vs model", rd_data, exp_rd);
  end

  task automatic do_write(input logic word, input logic [16:0] addr, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input int idx, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 9'(idx);
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      rd_addr = 9'(i);
      @(negedge clk);
      check(tag, rd_data, model[i]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_word = 1'b0; wr_addr = '0; wr_data = '0;
    mode5_en = 1'b1; big_mem_en = 1'b0; wide_line_en = 1'b0;
    sat_base = 8'h10; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;

    // R9: cleared after reset
    rd_check(0, 8'h00, "R9 reset idx0");
    rd_check(319, 8'h00, "R9 reset idx319");

    // Base 0x2000
    do_write(1'b1, 17'h02000, 16'hA1B2);
    rd_check(0, 8'hA1, "R7 word high byte");
    rd_check(1, 8'hB2, "R7 word low byte");
    do_write(1'b1, 17'h02008, 16'hC3D4);
    rd_check(4, 8'hC3, "R6 entry 1 index 4");
    rd_check(5, 8'hD4, "R6 entry 1 index 5");
    do_write(1'b1, 17'h02004, 16'hFFFF);
    rd_check(0, 8'hA1, "R4 bit2 write ignored");
    do_write(1'b0, 17'h02002, 16'h9955);
    rd_check(2, 8'h55, "R8 byte write");
    rd_check(3, 8'h00, "R8 paired byte untouched");
    do_write(1'b1, 17'h02278, 16'h1122);
    rd_check(316, 8'h11, "R5 last entry high");
    rd_check(317, 8'h22, "R6 last entry low");
    do_write(1'b1, 17'h02280, 16'hEEEE);
    do_write(1'b1, 17'h01FF8, 16'hEEEE);
    sweep("R5 outside window no effect");

    mode5_en = 1'b0;
    do_write(1'b1, 17'h02000, 16'hFFFF);
    rd_check(0, 8'hA1, "R4 mode5 off ignored");
    mode5_en = 1'b1;

    // R1/R3: base 0x2200, wide mode folds it to 0x2000
    sat_base = 8'h11;
    do_write(1'b1, 17'h02000, 16'h9999);
    rd_check(0, 8'hA1, "R1 below base 0x2200");
    wide_line_en = 1'b1;
    do_write(1'b1, 17'h02000, 16'h7788);
    rd_check(0, 8'h77, "R3 wide base aligned");
    rd_check(1, 8'h88, "R3 wide base low byte");
    wide_line_en = 1'b0;

    // R2: setting 0x90 gives 0x2000 or 0x12000
    sat_base = 8'h90;
    do_write(1'b1, 17'h02010, 16'h3344);
    rd_check(8, 8'h33, "R2 narrow base");
    big_mem_en = 1'b1;
    do_write(1'b1, 17'h02010, 16'h5555);
    rd_check(8, 8'h33, "R2 big base excludes low copy");
    do_write(1'b1, 17'h12010, 16'h99AA);
    rd_check(8, 8'h99, "R1 big base high");
    rd_check(9, 8'hAA, "R2 big base low");
    big_mem_en = 1'b0;
    sweep("R6 full contents");

    // R10 out-of-range reads
    rd_check(320, 8'h00, "R10 index 320");
    rd_check(511, 8'h00, "R10 index 511");

    // R11 read during write
    sat_base = 8'h10;
    @(negedge clk);
    rd_addr = 9'd0;
    wr_en = 1'b1; wr_word = 1'b1; wr_addr = 17'h02000; wr_data = 16'h5566;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 same-cycle old value", rd_data, 8'h77);
    @(negedge clk);
    check("R11 new value next read", rd_data, 8'h55);

    // R9 reset mid-run
    do_reset();
    sweep("R9 cleared by reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule